// File: doc/BRIEF.md
# Pipelined Banked Memory Array

This block is a deep single-port memory assembled from a grid of narrow, shallow storage tiles. Each tile is one bit wide. The grid has one row per bank and one column per data bit. The low part of the address picks a word inside every tile. The high part picks the bank. Only the addressed bank has its chip enable raised, so the other banks stay idle on every access.

The tile address passes through two register levels that are replicated as a tree, so that no address register drives more than a fixed number of loads. The high address bits, write enable and write data pass through the same two input stages. Reads then pass through a tile output register and a final output register. The bank index used to pick the read data is delayed so that it lines up with the data it selects.

Each operation takes four cycles from the request to `rd_valid`. The port accepts one operation per cycle.

Top module: `banked_mem_array`

## Requirements
- R1: While `rst_n` is low and after it is released, `rd_valid` is 0 and `rd_data` is 0 until the first read completes.
- R2: A read (`en`=1, `we`=0) sampled at a clock edge raises `rd_valid` for one cycle after the third following edge, with `rd_data` equal to the word last written to that address.
- R3: A write (`en`=1, `we`=1) never raises `rd_valid`. When `en`=0, the values on `we`, `addr` and `wdata` change no stored word.
- R4: The top `BANK_BITS` bits of `addr` select the bank and the low `TILE_AW` bits select the word inside it. A write to one bank leaves the word at the same offset in every other bank unchanged. At most one bank is enabled in any cycle.
- R5: One operation is accepted every cycle. Back-to-back reads to different banks each return their own data, in request order.
- R6: A read issued in the cycle right after a write to the same address returns the newly written data.
- R7: `rd_data` holds its value in every cycle in which `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Operation request |
| we | input | 1 | 1 = write, 0 = read (when `en`=1) |
| addr | input | BANK_BITS+TILE_AW | Word address: bank in the top bits, offset in the low bits |
| wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, updated only when a read completes |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` as a completed read |

## Verification
First a directed fill writes a distinct pattern to every address. Reads at one offset across all banks then show whether the bank decode and the write gating isolate the banks from each other. Reads to rotating banks issued on consecutive cycles separate a correctly delayed output select from one that is off by a cycle. A read right after a write to the same address exposes any ordering hazard in the pipeline. Disabled cycles that carry write data confirm that the enable gates storage. A long seeded random mix of reads, writes and idle cycles, checked against a bench model, covers the rest, and every idle cycle also checks that the output holds.

// File: rtl/banked_mem_pkg.sv
// Package: shared helper functions for the banked memory array.
// Assumes: arguments are positive integers.
package banked_mem_pkg;

    // Integer division rounded up, used to size the address copy tree.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/bank_tile.sv
// Module: bank_tile
// One-bit-wide storage tile with a registered read port.
// Assumes: ce gates every access; a write holds the output register;
// the storage itself is not reset.
module bank_tile #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic          din,
    output logic          dout
);
    localparam int DEPTH = 1 << AW;

    logic store [DEPTH];

    // Write port: commit a bit when this bank is enabled for write.
    always_ff @(posedge clk) begin
        if (ce && we) begin
            store[addr] <= din;
        end
    end

    // Read port: register the addressed bit on an enabled read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= 1'b0;
        end else if (ce && !we) begin
            dout <= store[addr];
        end
    end

    // R7: the tile output moves only after an enabled read
    a_r7_tile_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce && !we) |=> $stable(dout));

endmodule

// File: rtl/addr_fanout_tree.sv
// Module: addr_fanout_tree
// Two-level registered copy tree for the tile address. Each register
// drives at most FANOUT loads. The leaves trail the input by two cycles.
// Assumes: LOADS >= 1, FANOUT >= 2; the address path carries no reset.
module addr_fanout_tree
    import banked_mem_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LOADS  = 32,
    parameter int FANOUT = 8,
    localparam int LEAVES = ceil_div(LOADS, FANOUT),
    localparam int ROOTS  = ceil_div(LEAVES, FANOUT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [AW-1:0]              addr_in,
    output logic [LEAVES-1:0][AW-1:0]  leaf
);
    logic [ROOTS-1:0][AW-1:0] root;

    for (genvar r = 0; r < ROOTS; r++) begin : g_root
        // First level: one copy per group of FANOUT leaves.
        always_ff @(posedge clk) begin
            root[r] <= addr_in;
        end
    end

    for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
        // Second level: each leaf reloads from its own root copy.
        always_ff @(posedge clk) begin
            leaf[l] <= root[l / FANOUT];
        end

        // R2: every leaf carries the address from two edges earlier
        a_r2_leaf_delay: assert property (@(posedge clk) disable iff (!rst_n)
            leaf[l] == $past(addr_in, 2));
    end

endmodule

// File: rtl/read_select.sv
// Module: read_select
// Output side of the array. It delays the bank index and the read flag by
// one cycle to line up with the registered tile outputs, then registers
// the chosen bank's word on the final output.
// Assumes: tile_q is already registered inside the tiles.
module read_select #(
    parameter int BANK_BITS = 2,
    parameter int DATA_W    = 8,
    localparam int NUM_BANKS = 1 << BANK_BITS
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rd_req,
    input  logic [BANK_BITS-1:0]              bank,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]  tile_q,
    output logic [DATA_W-1:0]                 rd_data,
    output logic                              rd_valid
);
    logic                 vld_q;
    logic [BANK_BITS-1:0] sel_q;

    // Align the read flag and the select with the tile output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            sel_q <= '0;
        end else begin
            vld_q <= rd_req;
            sel_q <= bank;
        end
    end

    // Final stage: register the selected word and the valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= vld_q;
            if (vld_q) begin
                rd_data <= tile_q[sel_q];
            end
        end
    end

    // R2: a read that reached the tiles completes in the next cycle
    a_r2_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> rd_valid);

    // R7: the output word holds while no read completes
    a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_data));

endmodule

// File: rtl/banked_mem_array.sv
// Module: banked_mem_array
// Deep single-port memory built from a grid of one-bit tiles: the rows are
// banks and the columns are data bits. It has two input stages with a
// replicated address tree, a per-bank enable gated by the bank decode, and
// two output stages. The read latency is four cycles.
// Assumes: callers accept the fixed latency; BANK_BITS >= 1.
module banked_mem_array
    import banked_mem_pkg::*;
#(
    parameter int BANK_BITS = 2,
    parameter int TILE_AW   = 6,
    parameter int DATA_W    = 8,
    parameter int FANOUT    = 8,
    localparam int ADDR_W   = BANK_BITS + TILE_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int NUM_BANKS = 1 << BANK_BITS;
    localparam int NUM_TILES = NUM_BANKS * DATA_W;
    localparam int LEAVES    = ceil_div(NUM_TILES, FANOUT);

    logic                 en_a, we_a, en_b, we_b;
    logic [BANK_BITS-1:0] bank_a, bank_b;
    logic [DATA_W-1:0]    wdata_a, wdata_b;
    logic [NUM_BANKS-1:0] bank_ce, bank_we;
    logic [LEAVES-1:0][TILE_AW-1:0]       leaf_addr;
    logic [NUM_BANKS-1:0][DATA_W-1:0]     tile_q;

    // Input stages: control flags carry a reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_a <= 1'b0;
            we_a <= 1'b0;
            en_b <= 1'b0;
            we_b <= 1'b0;
        end else begin
            en_a <= en;
            we_a <= we;
            en_b <= en_a;
            we_b <= we_a;
        end
    end

    // Input stages: bank index and write data, no reset needed.
    always_ff @(posedge clk) begin
        bank_a  <= addr[ADDR_W-1:TILE_AW];
        wdata_a <= wdata;
        bank_b  <= bank_a;
        wdata_b <= wdata_a;
    end

    // Bank decode: enable only the addressed bank, write gated by the select.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            bank_ce[b] = en_b && (bank_b == BANK_BITS'(b));
            bank_we[b] = bank_ce[b] && we_b;
        end
    end

    addr_fanout_tree #(
        .AW     (TILE_AW),
        .LOADS  (NUM_TILES),
        .FANOUT (FANOUT)
    ) addr_tree_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_in (addr[TILE_AW-1:0]),
        .leaf    (leaf_addr)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar d = 0; d < DATA_W; d++) begin : g_bit
            bank_tile #(.AW(TILE_AW)) tile_i (
                .clk   (clk),
                .rst_n (rst_n),
                .ce    (bank_ce[b]),
                .we    (bank_we[b]),
                .addr  (leaf_addr[(b * DATA_W + d) / FANOUT]),
                .din   (wdata_b[d]),
                .dout  (tile_q[b][d])
            );
        end
    end

    read_select #(
        .BANK_BITS (BANK_BITS),
        .DATA_W    (DATA_W)
    ) rsel_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (en_b && !we_b),
        .bank     (bank_b),
        .tile_q   (tile_q),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // R4: never more than one bank enabled at once
    a_r4_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_ce));

    // R2: a completed read was requested exactly four edges earlier
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(en && !we, 4));

    // R3: a write request never yields a valid strobe
    a_r3_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !$past(we, 4));

endmodule

// File: tb/banked_mem_array_tb.sv
// Bench: seeded random plus directed stimulus against a word-level model.
module banked_mem_array_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BANK_BITS  = 2;
    localparam int TILE_AW    = 6;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = BANK_BITS + TILE_AW;
    localparam int WORDS      = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;

    int errors = 0;
    int checks = 0;

    logic [DATA_W-1:0] model [WORDS];
    logic              pv [4];
    logic [DATA_W-1:0] pd [4];
    string             ptag [4];
    logic [DATA_W-1:0] last_data = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    banked_mem_array #(
        .BANK_BITS (BANK_BITS),
        .TILE_AW   (TILE_AW),
        .DATA_W    (DATA_W),
        .FANOUT    (8)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .we       (we),
        .addr     (addr),
        .wdata    (wdata),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    function automatic logic [ADDR_W-1:0] mk_addr(input int bank, input int off);
        return ADDR_W'((bank << TILE_AW) | off);
    endfunction

    function automatic logic [DATA_W-1:0] fill_pattern(input int a);
        return DATA_W'((a * 37 + 11) ^ (a >> 3));
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle of stimulus, then compare against the bench pipeline.
    task automatic step(input logic e, input logic w, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input string tag);
        @(negedge clk);
        en = e; we = w; addr = a; wdata = d;
        @(posedge clk);
        #1;
        for (int i = 3; i > 0; i--) begin
            pv[i] = pv[i-1]; pd[i] = pd[i-1]; ptag[i] = ptag[i-1];
        end
        pv[0] = e && !w;
        pd[0] = model[a];
        ptag[0] = tag;
        if (e && w) model[a] = d;
        if (pv[3]) begin
            check(ptag[3], "rd_valid", DATA_W'(rd_valid), DATA_W'(1));
            check(ptag[3], "rd_data", rd_data, pd[3]);
            last_data = pd[3];
        end else begin
            check(tag, "rd_valid idle", DATA_W'(rd_valid), DATA_W'(0));
            check("R7", "rd_data hold", rd_data, last_data);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            pv[i] = 1'b0; pd[i] = '0; ptag[i] = "R1";
        end
        for (int i = 0; i < WORDS; i++) model[i] = '0;
        void'($urandom(32'h5eed));

        // R1: reset state
        repeat (4) @(posedge clk);
        #1;
        check("R1", "rd_valid in reset", DATA_W'(rd_valid), DATA_W'(0));
        check("R1", "rd_data in reset", rd_data, '0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0, '0, '0, "R1");
        step(1'b0, 1'b0, '0, '0, "R1");

        // R3: fill every word; writes raise no valid strobe
        for (int a = 0; a < WORDS; a++) begin
            step(1'b1, 1'b1, ADDR_W'(a), fill_pattern(a), "R3");
        end

        // R4: rewrite one offset in bank 1 only, then read that offset in all banks
        step(1'b1, 1'b1, mk_addr(1, 5), 8'hA5, "R4");
        for (int b = 0; b < (1 << BANK_BITS); b++) begin
            step(1'b1, 1'b0, mk_addr(b, 5), '0, "R4");
        end

        // R5: back-to-back reads rotating across banks
        step(1'b1, 1'b0, mk_addr(3, 9), '0, "R5");
        step(1'b1, 1'b0, mk_addr(0, 9), '0, "R5");
        step(1'b1, 1'b0, mk_addr(2, 9), '0, "R5");
        step(1'b1, 1'b0, mk_addr(1, 9), '0, "R5");
        step(1'b1, 1'b0, mk_addr(3, 63), '0, "R5");

        // R6: read immediately after a write to the same address
        step(1'b1, 1'b1, mk_addr(2, 17), 8'h3C, "R6");
        step(1'b1, 1'b0, mk_addr(2, 17), '0, "R6");
        step(1'b1, 1'b1, mk_addr(0, 0), 8'hFF, "R6");
        step(1'b1, 1'b0, mk_addr(0, 0), '0, "R6");

        // R7: idle gaps between reads keep the output steady
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, '0, '0, "R7");

        // R3: disabled cycles carrying write data store nothing
        step(1'b0, 1'b1, mk_addr(3, 40), 8'h00, "R3");
        step(1'b0, 1'b1, mk_addr(3, 40), 8'h77, "R3");
        step(1'b1, 1'b0, mk_addr(3, 40), '0, "R3");

        // R2: single isolated read and its latency
        step(1'b1, 1'b0, mk_addr(1, 33), '0, "R2");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, '0, '0, "R2");

        // R5: seeded random mix of reads, writes and idle cycles
        for (int i = 0; i < 3000; i++) begin
            logic e, w;
            e = ($urandom % 8) != 0;
            w = ($urandom % 2) != 0;
            step(e, w, ADDR_W'($urandom), DATA_W'($urandom), "R5");
        end

        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, '0, '0, "R7");

        summary();
        $finish;
    end

endmodule